// File: doc/BRIEF.md
# Chip-Select Timing Bus Controller

This block runs one read or one write at a time on a local bus that carries address and data over the same wires. An internal requester presents a request: an address, a direction, a bank index and write data. The controller then steps through a fixed sequence. In the address phase it drives the address with a latch strobe high. It waits a programmable setup delay, then asserts the chip select of the chosen bank together with output enable or write enable. It holds the strobes for a programmable number of wait cycles and ends the access with a one-cycle acknowledge. After a read it keeps the bus idle for a recovery interval, so that a slow device has time to release the shared wires.

Each bank carries its own set of timing options, supplied on a flat configuration vector. The options are the address-to-select setup code, an extra-setup flag, a relaxed-timing flag, a wait count, early write-enable negation, and extended read hold. The controller samples the selected bank's options when it accepts the request and keeps them until the access is complete. Every strobe is a decode of registered state, so every strobe changes state only just after a rising clock edge.

Top module: `csBusCtl`

## Requirements
- R1: While reset is low, `reqReady` is 1. All `csN` bits, `oeN` and `weN` are 1. `ale`, `ack` and `busDrive` are 0, and `rdData` is 0.
- R2: A request is accepted on a rising edge where `reqValid` and `reqReady` are both 1. The cycle that follows is the address phase and lasts exactly one cycle. In it `ale` is 1, `busDrive` is 1, `busOut` equals the request address, and no chip select is active.
- R3: Bank b's options are `bankCfg[b*CFG_W +: CFG_W]`. Bits 1:0 are the setup code, bit 2 is extra setup, bit 3 is relaxed, bit 4 is early write negation, bit 5 is extended hold, and bits 6 and up are the wait count. After the address phase, `csN[bank]` goes low once (setup code + relaxed) further cycles have passed. Only that bank's line goes low.
- R4: On a read, `oeN` goes low one cycle after chip select. It goes low in the same cycle as chip select when extra setup is 1 and the setup code is 2 or 3. `oeN` goes high on the same edge as chip select, and stays high on writes.
- R5: After the enable delay of R4, the strobe span lasts 1 + wait cycles. With relaxed set it lasts 1 + 2*wait cycles.
- R6: On a write, `weN` uses the same delay rule as `oeN` and stays low for the strobe span of R5. `busDrive` is 1 and `busOut` equals the write data in every chip-select cycle. `oeN` stays high.
- R7: On a write with early write negation set, chip select stays active for one more cycle after `weN` goes high. Reads ignore this bit.
- R8: `ack` is 1 for exactly one cycle, which is the last chip-select cycle. `rdData` then takes the value that `busIn` has at the rising edge ending that cycle, and keeps it until the next read.
- R9: After the last chip-select cycle of a read, `reqReady` stays 0 and all strobes stay inactive for 1 + H cycles. H is 0, 1, 4 or 8 for (relaxed, extended hold) = (0,0), (0,1), (1,0) and (1,1). A write has no recovery.
- R10: A `reqValid` that arrives while `reqReady` is 0 is ignored. It does not change the running access or its recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | BANK_W | Target bank index |
| reqAddr | input | BUS_W | Access address |
| reqWdata | input | BUS_W | Write data |
| rdData | output | BUS_W | Captured read data |
| ack | output | 1 | One-cycle completion pulse |
| bankCfg | input | NUM_BANKS*CFG_W | Per-bank timing options |
| busOut | output | BUS_W | Multiplexed address/data out |
| busIn | input | BUS_W | Multiplexed data in |
| busDrive | output | 1 | Output enable for the shared bus |
| ale | output | 1 | Address latch strobe |
| csN | output | NUM_BANKS | Active-low chip selects |
| oeN | output | 1 | Active-low output enable |
| weN | output | 1 | Active-low write enable |

## Verification
The properties assume three things about the inputs. `reqBank` stays below the bank count. Reset is released synchronously. The options of the selected bank do not change between acceptance and the end of recovery. The stimulus writes the whole configuration vector before it raises `reqValid`. It always names a bank in range, and it leaves the options untouched until the controller is idle again. The only time the stimulus raises `reqValid` outside an idle cycle is on purpose: it presents conflicting requests while the controller is busy, and the expected timeline must stay unchanged.

// File: rtl/csbus_pkg.sv
package csbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STRB,
    PH_RECOV
  } phase_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic load;
    logic ale;
    logic cs;
    logic oe;
    logic we;
    logic drvData;
    logic ack;
    logic capture;
  } strobe_t;

  // option field positions inside one bank slice
  localparam int SETUP_LSB = 0;
  localparam int XS_BIT    = 2;
  localparam int REL_BIT   = 3;
  localparam int EARLY_BIT = 4;
  localparam int HOLD_BIT  = 5;
  localparam int WAIT_LSB  = 6;

  // idle cycles after a read: turnaround plus programmable hold
  function automatic logic [3:0] holdCycles(input logic rel, input logic ext);
    logic [3:0] res;
    unique case ({rel, ext})
      2'b00:   res = 4'd1;
      2'b01:   res = 4'd2;
      2'b10:   res = 4'd5;
      default: res = 4'd9;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/csbusCtrl.sv
module csbusCtrl
  import csbus_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int WAIT_W    = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CFG_W    = WAIT_W + 6,
  localparam int CNT_W    = WAIT_W + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       reqWrite,
  input  logic [BANK_W-1:0]          reqBank,
  input  logic [NUM_BANKS*CFG_W-1:0] bankCfg,
  output logic                       reqReady,
  output strobe_t                    stb
);

  logic [CFG_W-1:0] cfgArr [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slice
    assign cfgArr[b] = bankCfg[b*CFG_W +: CFG_W];
  end

  logic [CFG_W-1:0]  selCfg;
  logic [1:0]        fSetup;
  logic              fXs, fRel, fEarly, fHold;
  logic [WAIT_W-1:0] fWait;

  assign selCfg = cfgArr[reqBank];
  assign fSetup = selCfg[SETUP_LSB +: 2];
  assign fXs    = selCfg[XS_BIT];
  assign fRel   = selCfg[REL_BIT];
  assign fEarly = selCfg[EARLY_BIT];
  assign fHold  = selCfg[HOLD_BIT];
  assign fWait  = selCfg[WAIT_LSB +: WAIT_W];

  // timing derived from the selected options at acceptance
  logic [2:0]       nCsDly;
  logic             nOeDly;
  logic [CNT_W-1:0] nWaitEff, nWeEnd, nLast;

  assign nCsDly   = {1'b0, fSetup} + {2'b00, fRel};
  assign nOeDly   = !(fXs && fSetup[1]);
  assign nWaitEff = fRel ? {1'b0, fWait, 1'b0} : {2'b00, fWait};
  assign nWeEnd   = nWaitEff + CNT_W'(nOeDly) + CNT_W'(1);
  assign nLast    = nWeEnd - CNT_W'(1) + CNT_W'(reqWrite && fEarly);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             isRd;
  logic [2:0]       csDly;
  logic             oeDly;
  logic [CNT_W-1:0] weEnd, strbLast;
  logic [3:0]       holdLast;
  logic             accept;

  assign accept   = reqValid && (phase == PH_IDLE);
  assign reqReady = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      isRd     <= 1'b0;
      csDly    <= '0;
      oeDly    <= 1'b1;
      weEnd    <= '0;
      strbLast <= '0;
      holdLast <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase    <= PH_ADDR;
            cnt      <= '0;
            isRd     <= !reqWrite;
            csDly    <= nCsDly;
            oeDly    <= nOeDly;
            weEnd    <= nWeEnd;
            strbLast <= nLast;
            holdLast <= holdCycles(fRel, fHold) - 4'd1;
          end
        end
        PH_ADDR: begin
          cnt   <= '0;
          phase <= (csDly == 3'd0) ? PH_STRB : PH_SETUP;
        end
        PH_SETUP: begin
          if (int'(cnt) == int'(csDly) - 1) begin
            cnt   <= '0;
            phase <= PH_STRB;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_STRB: begin
          if (cnt == strbLast) begin
            cnt   <= '0;
            phase <= isRd ? PH_RECOV : PH_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_RECOV: begin
          if (int'(cnt) == int'(holdLast)) begin
            cnt   <= '0;
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    stb      = '0;
    stb.load = accept;
    stb.ale  = (phase == PH_ADDR);
    if (phase == PH_STRB) begin
      stb.cs      = 1'b1;
      stb.oe      = isRd && (cnt >= CNT_W'(oeDly));
      stb.we      = !isRd && (cnt >= CNT_W'(oeDly)) && (cnt < weEnd);
      stb.drvData = !isRd;
      stb.ack     = (cnt == strbLast);
      stb.capture = isRd && (cnt == strbLast);
    end
  end

endmodule

// File: rtl/csbusData.sv
module csbusData
  import csbus_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BUS_W     = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [BUS_W-1:0]     reqAddr,
  input  logic [BUS_W-1:0]     reqWdata,
  input  logic [BUS_W-1:0]     busIn,
  output logic [BUS_W-1:0]     busOut,
  output logic                 busDrive,
  output logic                 ale,
  output logic [NUM_BANKS-1:0] csN,
  output logic                 oeN,
  output logic                 weN,
  output logic                 ack,
  output logic [BUS_W-1:0]     rdData
);

  logic [BUS_W-1:0]  addrQ, dataQ, rdQ;
  logic [BANK_W-1:0] bankQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      bankQ <= '0;
      rdQ   <= '0;
    end else begin
      if (stb.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
        bankQ <= reqBank;
      end
      if (stb.capture) begin
        rdQ <= busIn;
      end
    end
  end

  assign busOut   = stb.ale ? addrQ : (stb.drvData ? dataQ : '0);
  assign busDrive = stb.ale | stb.drvData;
  assign ale      = stb.ale;
  assign oeN      = !stb.oe;
  assign weN      = !stb.we;
  assign ack      = stb.ack;
  assign rdData   = rdQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    assign csN[b] = !(stb.cs && (bankQ == BANK_W'(b)));
  end

endmodule

// File: rtl/csBusCtl.sv
module csBusCtl
  import csbus_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BUS_W     = 16,
  parameter int WAIT_W    = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CFG_W    = WAIT_W + 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic                       reqWrite,
  input  logic [BANK_W-1:0]          reqBank,
  input  logic [BUS_W-1:0]           reqAddr,
  input  logic [BUS_W-1:0]           reqWdata,
  output logic [BUS_W-1:0]           rdData,
  output logic                       ack,
  input  logic [NUM_BANKS*CFG_W-1:0] bankCfg,
  output logic [BUS_W-1:0]           busOut,
  input  logic [BUS_W-1:0]           busIn,
  output logic                       busDrive,
  output logic                       ale,
  output logic [NUM_BANKS-1:0]       csN,
  output logic                       oeN,
  output logic                       weN
);

  strobe_t stb;

  csbusCtrl #(.NUM_BANKS(NUM_BANKS), .WAIT_W(WAIT_W)) ctrlI (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqBank), .bankCfg(bankCfg), .reqReady(reqReady), .stb(stb)
  );

  csbusData #(.NUM_BANKS(NUM_BANKS), .BUS_W(BUS_W)) dataI (
    .clk(clk), .rstN(rstN), .stb(stb), .reqBank(reqBank), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busIn(busIn), .busOut(busOut), .busDrive(busDrive),
    .ale(ale), .csN(csN), .oeN(oeN), .weN(weN), .ack(ack), .rdData(rdData)
  );

endmodule

// File: rtl/csBusCtlChk.sv
module csBusCtlChk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqReady,
  input logic                 ale,
  input logic                 busDrive,
  input logic [NUM_BANKS-1:0] csN,
  input logic                 oeN,
  input logic                 weN,
  input logic                 ack
);

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rstN) $onehot0(~csN)); // R3
  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN) !oeN |-> !(&csN)); // R4
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rstN) (oeN || weN)); // R6
  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN) !weN |-> !(&csN)); // R6
  AST_WE_EARLY: assert property (@(posedge clk) disable iff (!rstN) ($rose(weN) && !(&csN)) |-> ack); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN) ack |=> !ack); // R8
  AST_ACK_IN_CS: assert property (@(posedge clk) disable iff (!rstN) ack |-> !(&csN)); // R8
  AST_ACK_LAST: assert property (@(posedge clk) disable iff (!rstN) ack |=> (&csN)); // R8
  AST_ALE_ONE: assert property (@(posedge clk) disable iff (!rstN) ale |=> !ale); // R2
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rstN) ale |-> (busDrive && (&csN))); // R2
  AST_READ_RECOV: assert property (@(posedge clk) disable iff (!rstN) $rose(oeN) |-> !reqReady); // R9
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN) reqReady |-> ((&csN) && !ale && !ack)); // R10

endmodule

bind csBusCtl csBusCtlChk #(.NUM_BANKS(NUM_BANKS)) chkI (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .ale(ale), .busDrive(busDrive),
  .csN(csN), .oeN(oeN), .weN(weN), .ack(ack)
);

// File: tb/csBusCtl_tb_top.sv
module csBusCtl_tb_top;

  localparam int NB = 4;
  localparam int BW = 16;
  localparam int WW = 4;
  localparam int CW = WW + 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic             reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]       reqBank = '0;
  logic [BW-1:0]    reqAddr = '0, reqWdata = '0, busIn = '0;
  logic [NB*CW-1:0] bankCfg = '0;
  wire              reqReady, ack, busDrive, ale, oeN, weN;
  wire  [BW-1:0]    rdData, busOut;
  wire  [NB-1:0]    csN;

  csBusCtl #(.NUM_BANKS(NB), .BUS_W(BW), .WAIT_W(WW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBank(reqBank), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdData(rdData), .ack(ack), .bankCfg(bankCfg), .busOut(busOut), .busIn(busIn),
    .busDrive(busDrive), .ale(ale), .csN(csN), .oeN(oeN), .weN(weN)
  );

  typedef struct {
    bit ale, cs, oe, we, ack, drv, rdy, cap;
    int bus;
    int bank;
  } cyc_t;

  cyc_t q[$];
  int nRun = 0, nFail = 0;
  bit done = 1'b0;
  bit capPending = 1'b0;
  bit poke = 1'b0;
  logic [BW-1:0] expRd = '0, rdVal = '0;
  int csCyc, oeCyc, weCyc, busyCyc;

  function automatic cyc_t mk(input bit rdy);
    cyc_t c;
    c.ale = 0; c.cs = 0; c.oe = 0; c.we = 0; c.ack = 0; c.drv = 0; c.cap = 0;
    c.rdy = rdy; c.bus = 0; c.bank = 0;
    return c;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    cyc_t e;
    logic [NB-1:0] expCs;
    @(posedge clk);
    #2;
    if (capPending) begin
      expRd = busIn;
      busIn = ~busIn;
      capPending = 1'b0;
    end
    if (q.size() > 0) e = q.pop_front();
    else e = mk(1'b1);
    expCs = e.cs ? ~(NB'(1) << e.bank) : '1;
    chk("R2", "ale", int'(ale), int'(e.ale));
    chk("R3", "csN", int'(csN), int'(expCs));
    chk("R4", "oeN", int'(oeN), int'(!e.oe));
    chk("R6", "weN", int'(weN), int'(!e.we));
    chk("R6", "busDrive", int'(busDrive), int'(e.drv));
    chk(e.ale ? "R2" : "R6", "busOut", int'(busOut), e.bus);
    chk("R8", "ack", int'(ack), int'(e.ack));
    chk("R9", "reqReady", int'(reqReady), int'(e.rdy));
    chk("R8", "rdData", int'(rdData), int'(expRd));
    if (!(&csN)) csCyc++;
    if (!oeN) oeCyc++;
    if (!weN) weCyc++;
    if (!reqReady) busyCyc++;
    if (e.cap) begin
      busIn = rdVal;
      capPending = 1'b1;
    end
    // R10: conflicting request held while busy
    if (poke) reqValid = (q.size() > 0);
  endtask

  task automatic access(input bit wr, input int bank, input int addr, input int wdata,
                        input int setup, input int xs, input int rel, input int early,
                        input int hold, input int wt, input bit pk);
    int csDly, oeDly, act, trail, len, rec;
    cyc_t c;
    for (int b = 0; b < NB; b++) bankCfg[b*CW +: CW] = '1;
    bankCfg[bank*CW +: CW] = {WW'(wt), 1'(hold), 1'(early), 1'(rel), 1'(xs), 2'(setup)};
    csDly = setup + rel;
    oeDly = (xs != 0 && setup >= 2) ? 0 : 1;
    act   = 1 + ((rel != 0) ? 2 * wt : wt);
    trail = (wr && early != 0) ? 1 : 0;
    len   = oeDly + act + trail;
    rec   = wr ? 0 : 1 + ((rel != 0) ? ((hold != 0) ? 8 : 4) : ((hold != 0) ? 1 : 0));
    c = mk(1'b0); c.ale = 1; c.drv = 1; c.bus = addr;
    q.push_back(c);
    repeat (csDly) q.push_back(mk(1'b0));
    for (int i = 0; i < len; i++) begin
      c = mk(1'b0);
      c.cs = 1; c.bank = bank;
      c.oe = !wr && i >= oeDly;
      c.we = wr && i >= oeDly && i < oeDly + act;
      c.ack = (i == len - 1);
      c.drv = wr;
      c.bus = wr ? wdata : 0;
      c.cap = !wr && c.ack;
      q.push_back(c);
    end
    repeat (rec) q.push_back(mk(1'b0));
    rdVal = BW'(addr * 7 + 'h1357);
    busIn = ~rdVal;
    csCyc = 0; oeCyc = 0; weCyc = 0; busyCyc = 0;
    reqValid = 1'b1; reqWrite = wr; reqBank = 2'(bank);
    reqAddr = BW'(addr); reqWdata = BW'(wdata);
    step();
    reqValid = pk;
    poke = pk;
    if (pk) begin
      reqWrite = !wr; reqBank = 2'(bank ^ 1); reqAddr = ~reqAddr; reqWdata = ~reqWdata;
    end
    while (q.size() > 0) step();
    poke = 1'b0;
    reqValid = 1'b0;
    chk("R5", "strobe span", csCyc, len);
    if (wr) chk("R7", "cs beyond we", csCyc - weCyc, oeDly + trail);
    else chk("R4", "cs before oe", csCyc - oeCyc, oeDly);
    chk(pk ? "R10" : "R9", "busy cycles", busyCyc, 1 + csDly + len + rec);
    step();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R1", "reqReady", int'(reqReady), 1);
    chk("R1", "csN", int'(csN), 'hF);
    chk("R1", "strobes", int'({oeN, weN, ale, ack, busDrive}), 'b11000);
    chk("R1", "rdData", int'(rdData), 0);
    rstN = 1'b1;
    step();
    //     wr bank addr    wdata   set xs rel erl hld wt  pk
    access(0, 0, 'h0100, 0,       0, 0, 0, 0, 0, 0, 0);
    access(1, 1, 'h0204, 'hA55A,  1, 0, 0, 0, 0, 2, 0);
    access(0, 2, 'h0308, 0,       2, 1, 0, 0, 1, 1, 0);
    access(0, 3, 'h040C, 0,       3, 1, 1, 0, 0, 1, 0);
    access(0, 1, 'h0510, 0,       2, 0, 1, 0, 1, 0, 0);
    access(1, 0, 'h0614, 'h3C3C,  0, 0, 1, 1, 0, 1, 0);
    access(1, 3, 'h0718, 'hF00F,  3, 1, 0, 1, 0, 0, 0);
    access(0, 2, 'h081C, 0,       1, 1, 0, 1, 1, 3, 1);
    access(1, 1, 'h0920, 'h1234,  0, 1, 0, 0, 1, 3, 1);
    access(0, 0, 'h0A24, 0,       0, 0, 1, 0, 1, 15, 0);
    access(1, 2, 'h0B28, 'hBEEF,  2, 0, 1, 1, 1, 15, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule